// File: doc/BRIEF.md
# Reference Frequency Divider Chain

This block turns a 4.096 MHz reference clock into a 400 Hz square wave with equal high and low times. The divide ratio is 10240, built as a fixed mixed-radix cascade: a 7-bit binary counter (divide by 128), a 3-bit binary counter (divide by 8), a modulo-5 counter (divide by 5) and a toggle flop (divide by 2). The modulo-5 stage's top bit is high for one count in five. It is a pulse, not a square wave, so the final toggle stage is needed to bring the duty cycle back to one half.

Everything runs on one clock. Each stage advances only when the stage before it asserts a one-cycle advance strobe at its wrap point. No stage output is used as a clock. The top bit of each counter is brought out as a tap, so the intermediate rates can be observed. The reset input clears the chain asynchronously. Its release passes through a two-flop synchronizer, so the chain starts from a known phase.

Top module: `ref_divider_chain`

## Requirements
- R1: While rst_n is low, all four outputs are 0. A low level on rst_n forces them to 0 without waiting for a clock edge.
- R2: Let k be the number of rising clk edges since rst_n went high, minus 2, floored at 0. The chain counts its first input cycle on the third rising edge after the release.
- R3: tap_div128 is 1 exactly when (k mod 128) >= 64. This gives a period of 128 input cycles and a 50% duty cycle.
- R4: tap_div1024 is 1 exactly when (k mod 1024) >= 512. It changes only in the cycle after tap_div128 goes from 1 to 0.
- R5: pulse_div5120 is 1 exactly when (k mod 5120) >= 4096, so it is high for 1024 cycles and low for 4096. It changes only in the cycle after tap_div1024 goes from 1 to 0.
- R6: square_out equals floor(k / 5120) mod 2. It has a period of 10240 cycles and is high for 5120 of them. It changes only in the cycle after pulse_div5120 goes from 1 to 0.
- R7: The first rising edge of square_out after reset occurs at k = 5120.
- R8: Reasserting rst_n in the middle of a run restarts the whole chain at phase zero. After the next release, pulse_div5120 first rises at k = 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (4.096 MHz in the target use) |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| tap_div128 | output | 1 | Top bit of the first binary stage, clk / 128 |
| tap_div1024 | output | 1 | Top bit of the second binary stage, clk / 1024 |
| pulse_div5120 | output | 1 | Top bit of the modulo-5 stage, clk / 5120, 20% high |
| square_out | output | 1 | Final toggle output, clk / 10240, 50% duty |

## Verification
The reference model predicts every tap on every cycle from the count since reset. Two full output periods from a clean reset check each stage's wrap point and the order in which the stages cascade. The phase of the first output edge separates a toggle on the falling edge of the pulse from one on its rising edge. An asynchronous reset is then dropped mid-run, part way through a pulse period, and a second run follows. This run checks that no stage keeps partial state, because a leftover count would move the first pulse away from k = 4096.

// File: rtl/div_chain_pkg.sv
package div_chain_pkg;

  // Number of counting stages ahead of the final toggle flop.
  localparam int unsigned NUM_COUNTERS = 3;

  // Modulus of counting stage idx: two binary stages, then one odd stage.
  function automatic int unsigned stage_mod(input int unsigned idx,
                                            input int unsigned a_bits,
                                            input int unsigned b_bits,
                                            input int unsigned c_mod);
    int unsigned m;
    case (idx)
      0:       m = 32'd1 << a_bits;
      1:       m = 32'd1 << b_bits;
      default: m = c_mod;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/div_reset_sync.sv
module div_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_q = shift_q[STAGES-1];

endmodule

// File: rtl/div_stage_counter.sv
module div_stage_counter #(
  parameter int unsigned MOD = 2,
  localparam int unsigned W  = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic tap_o,
  output logic wrap_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == W'(MOD - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i) begin
      if (at_last) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // The advance strobe for the next stage fires on this stage's wrap,
  // i.e. the cycle in which the top bit falls (or, for an odd modulus,
  // the cycle in which the top-count state is left).
  assign wrap_o = adv_i & at_last;
  assign tap_o  = cnt_q[W-1];

endmodule

// File: rtl/div_toggle_stage.sv
module div_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  always_comb begin
    q_d = q_q;
    if (adv_i) begin
      q_d = ~q_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/ref_divider_chain.sv
module ref_divider_chain #(
  parameter int unsigned A_BITS      = 7,
  parameter int unsigned B_BITS      = 3,
  parameter int unsigned C_MOD       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tap_div128,
  output logic tap_div1024,
  output logic pulse_div5120,
  output logic square_out
);

  import div_chain_pkg::*;

  localparam int unsigned NC = NUM_COUNTERS;

  logic          rst_q;
  logic [NC:0]   adv;
  logic [NC-1:0] stage_tap;

  div_reset_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // The first stage counts every input cycle.
  assign adv[0] = 1'b1;

  for (genvar gi = 0; gi < NC; gi++) begin : g_stage
    localparam int unsigned MOD_I = stage_mod(gi, A_BITS, B_BITS, C_MOD);

    div_stage_counter #(
      .MOD (MOD_I)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_q),
      .adv_i  (adv[gi]),
      .tap_o  (stage_tap[gi]),
      .wrap_o (adv[gi+1])
    );
  end

  div_toggle_stage u_tgl (
    .clk   (clk),
    .rst_n (rst_q),
    .adv_i (adv[NC]),
    .q_o   (square_out)
  );

  assign tap_div128    = stage_tap[0];
  assign tap_div1024   = stage_tap[1];
  assign pulse_div5120 = stage_tap[2];

endmodule

// File: rtl/div_chain_checker.sv
module div_chain_checker #(
  parameter int unsigned A_BITS = 7,
  parameter int unsigned B_BITS = 3,
  parameter int unsigned C_MOD  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic rst_q,
  input logic tap_div128,
  input logic tap_div1024,
  input logic pulse_div5120,
  input logic square_out
);

  localparam int HALF_A   = 2 ** (A_BITS - 1);
  localparam int HIGH_C   = 2 ** (A_BITS + B_BITS);
  localparam int HALF_OUT = HIGH_C * C_MOD;

  logic prev_a, prev_c, prev_o;
  int   run_a, run_c, run_o;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prev_a <= 1'b0;
      prev_c <= 1'b0;
      prev_o <= 1'b0;
      run_a  <= 0;
      run_c  <= 0;
      run_o  <= 0;
    end else begin
      prev_a <= tap_div128;
      prev_c <= pulse_div5120;
      prev_o <= square_out;
      run_a  <= (tap_div128    != prev_a) ? 1 : run_a + 1;
      run_c  <= (pulse_div5120 != prev_c) ? 1 : run_c + 1;
      run_o  <= (square_out    != prev_o) ? 1 : run_o + 1;
    end
  end

  // R1: outputs are cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!tap_div128 && !tap_div1024 && !pulse_div5120 && !square_out));

  // R3: each level of the first tap lasts half a 128-cycle period
  p_half128_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (tap_div128 != prev_a) |-> (run_a == HALF_A));

  // R4: second tap moves only after the first tap falls
  p_cascade1024_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (tap_div1024 != $past(tap_div1024)) |-> ($past(tap_div128) && !tap_div128));

  // R5: pulse moves only after the second tap falls
  p_cascade5120_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (pulse_div5120 != $past(pulse_div5120)) |-> ($past(tap_div1024) && !tap_div1024));

  // R5: pulse high time is one second-stage period
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (prev_c && !pulse_div5120) |-> (run_c == HIGH_C));

  // R6: square output toggles only after the pulse falls
  p_toggle_edge_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (square_out != $past(square_out)) |-> ($past(pulse_div5120) && !pulse_div5120));

  // R6: every square output level lasts half its period
  p_half_square_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (square_out != prev_o) |-> (run_o == HALF_OUT));

endmodule

bind ref_divider_chain div_chain_checker #(
  .A_BITS (A_BITS),
  .B_BITS (B_BITS),
  .C_MOD  (C_MOD)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_q         (rst_q),
  .tap_div128    (tap_div128),
  .tap_div1024   (tap_div1024),
  .pulse_div5120 (pulse_div5120),
  .square_out    (square_out)
);

// File: tb/ref_divider_chain_test.sv
`timescale 1ns/1ps
module ref_divider_chain_test;

  localparam int P_A   = 128;
  localparam int P_B   = 1024;
  localparam int P_C   = 5120;
  localparam int P_OUT = 10240;

  logic clk = 1'b0;
  logic rst_n;
  logic tap_div128, tap_div1024, pulse_div5120, square_out;

  always #2.5 clk = ~clk;

  ref_divider_chain uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tap_div128    (tap_div128),
    .tap_div1024   (tap_div1024),
    .pulse_div5120 (pulse_div5120),
    .square_out    (square_out)
  );

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit model_on = 1'b0;
  bit phase1   = 1'b1;
  int hi_out   = 0;
  int hi_pulse = 0;
  int first_a_edges = -1;
  logic prev_out = 1'b0, prev_pulse = 1'b0, prev_a = 1'b0;
  int rises_out[$];
  int rises_pulse[$];

  always @(posedge clk) begin
    if (!rst_n) edges = 0;
    else        edges = edges + 1;
  end

  function automatic int kval();
    return (edges > 2) ? edges - 2 : 0;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b (k=%0d)", req, act, exp, kval());
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle reference comparison, sampled away from the active edge.
  always @(negedge clk) begin
    if (model_on) begin
      int k;
      k = kval();
      check_bit("R3 tap_div128",    tap_div128,    (k % P_A) >= P_A / 2);
      check_bit("R4 tap_div1024",   tap_div1024,   (k % P_B) >= P_B / 2);
      check_bit("R5 pulse_div5120", pulse_div5120, (k % P_C) >= P_C - P_B);
      check_bit("R6 square_out",    square_out,    ((k / P_C) % 2) == 1);
      if (rst_n) begin
        if (square_out && !prev_out)      rises_out.push_back(k);
        if (pulse_div5120 && !prev_pulse) rises_pulse.push_back(k);
        if (tap_div128 && !prev_a && first_a_edges < 0) first_a_edges = edges;
        if (phase1 && k < 2 * P_OUT && square_out)          hi_out++;
        if (phase1 && k >= P_C && k < 2 * P_C && pulse_div5120) hi_pulse++;
      end
      prev_out   = square_out;
      prev_pulse = pulse_div5120;
      prev_a     = tap_div128;
    end
  end

  task automatic summary_and_finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary_and_finish();
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check_bit("R1 tap_div128 reset",    tap_div128,    1'b0);
    check_bit("R1 tap_div1024 reset",   tap_div1024,   1'b0);
    check_bit("R1 pulse_div5120 reset", pulse_div5120, 1'b0);
    check_bit("R1 square_out reset",    square_out,    1'b0);

    rst_n    = 1'b1;
    model_on = 1'b1;
    while (kval() < 2 * P_OUT + 20) @(negedge clk);

    // R2: first tap rises on edge 64 of counting, two edges after release
    check_int("R2 edges to first tap_div128 rise", first_a_edges, P_A / 2 + 2);
    // R7: first square rise phase
    check_int("R7 first square_out rise k", (rises_out.size() > 0) ? rises_out[0] : -1, P_C);
    // R6: period and duty
    check_int("R6 square_out period",
              (rises_out.size() > 1) ? rises_out[1] - rises_out[0] : -1, P_OUT);
    check_int("R6 square_out high cycles over two periods", hi_out, P_OUT);
    // R5: pulse width within one period
    check_int("R5 pulse_div5120 high cycles per period", hi_pulse, P_B);

    // R8: asynchronous mid-run reset, part way through a pulse period
    phase1 = 1'b0;
    while (kval() % P_C != 2500) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check_bit("R1 async clear tap_div128",    tap_div128,    1'b0);
    check_bit("R1 async clear tap_div1024",   tap_div1024,   1'b0);
    check_bit("R1 async clear pulse_div5120", pulse_div5120, 1'b0);
    check_bit("R1 async clear square_out",    square_out,    1'b0);
    repeat (3) @(negedge clk);
    rises_pulse.delete();
    rst_n = 1'b1;
    while (kval() < P_C + 10) @(negedge clk);
    check_int("R8 first pulse rise after restart k",
              (rises_pulse.size() > 0) ? rises_pulse[0] : -1, P_C - P_B);

    model_on = 1'b0;
    summary_and_finish();
  end

endmodule